// File: doc/BRIEF.md
# Block Queue Channel With Random-Access Slots

This block links a producing process to a consuming process by passing whole blocks of data words rather than single words. Storage is a ring of `NUM_BLK` slots, and each slot holds `BLK_WORDS` words. The producer always owns one slot, which it fills, and the consumer always owns one slot, which it drains. Each side reaches any word of the slot it owns through a word address and a two-bit command. Because of this, a block can be written in one order and read back in another, such as a zigzag scan. A side can also use its own slot as scratch storage.

A commit command ends a side's use of its slot. When the producer commits, its slot joins the queue and becomes visible to the consumer. When the consumer commits, its slot goes back to the producer. The producer sees a full flag and the consumer sees an empty flag. These flags stall the producer when every slot is committed and still unreleased, and stall the consumer when nothing is waiting.

The command encoding is the same on both sides: 0 means idle, 1 means read, 2 means write, 3 means commit.

Top module: `blkq_top`

## Requirements
- R1: After reset, `cns_empty` is 1, `prd_full` is 0, and both read-data outputs are 0.
- R2: A read command (1) on either side returns the addressed word of that side's slot on the read-data output after the next clock edge. On a cycle with any other command, that side's read data holds its value.
- R3: A producer commit (3) while not full makes its slot the next block for the consumer, so `cns_empty` is 0 after that edge. A consumer commit while not empty frees the head slot.
- R4: The consumer may read the words of its slot in any address order and gets each word the producer wrote there.
- R5: Blocks reach the consumer in the order the producer committed them.
- R6: `prd_full` is 1 while all `NUM_BLK` slots are committed and unreleased. While full, producer write (2) and commit (3) commands have no effect, neither on stored data nor on the slot count.
- R7: `cns_empty` is 1 while no committed block waits. While empty, consumer read, write and commit commands have no effect: read data holds, storage is unchanged, and the count does not go below zero.
- R8: Slot indices on both sides wrap modulo `NUM_BLK`, so more than `NUM_BLK` blocks can pass through in order.
- R9: When a producer commit and a consumer commit are both accepted in the same cycle, the slot count is unchanged and so are both flags.
- R10: The consumer may write words of its own slot (2) while not empty and read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| prd_op | input | 2 | Producer command: 0 idle, 1 read, 2 write, 3 commit |
| prd_addr | input | AW | Word address within the producer slot |
| prd_wdata | input | DATA_W | Producer write data |
| prd_rdata | output | DATA_W | Producer read data, valid after the edge following a read |
| prd_full | output | 1 | Every slot is committed and unreleased |
| cns_op | input | 2 | Consumer command: 0 idle, 1 read, 2 write, 3 commit |
| cns_addr | input | AW | Word address within the consumer slot |
| cns_wdata | input | DATA_W | Consumer write data |
| cns_rdata | output | DATA_W | Consumer read data, valid after the edge following a read |
| cns_empty | output | 1 | No committed block is waiting |

## Verification
The bench fills every slot and then issues a producer write and a producer commit. A design that did not ignore them would overwrite the consumer's head block, or it would count a fifth block and never report empty after draining. With the queue empty, the bench issues consumer read, write and commit commands. A design that accepted them would change the read data, corrupt the slot the producer is filling, or underflow the count. The bench also pushes blocks through several full turns of the ring to expose a wrong wrap, reads in a scrambled address order to expose address decoding that assumes a fixed order, and commits on both sides in the same cycle to expose a count that applies only one of the two updates.

// File: rtl/blkq_pkg.sv
// Shared command encoding for the block queue channel.
package blkq_pkg;
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_READ   = 2'd1,
        OP_WRITE  = 2'd2,
        OP_COMMIT = 2'd3
    } blkq_op_e;
endpackage

// File: rtl/blkq_ptr.sv
// Slot index counter: steps by one on adv and wraps from NUM_BLK-1 to 0.
// Assumes adv is raised only when the owning side may release its slot.
module blkq_ptr #(
    parameter int NUM_BLK = 4,
    localparam int PW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    // Advance the index with modulo wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == PW'(NUM_BLK - 1)) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/blkq_occ.sv
// Committed-slot counter and the full/empty flags derived from it.
// Assumes put is never raised when full and take is never raised when empty.
module blkq_occ #(
    parameter int NUM_BLK = 4,
    localparam int CW = $clog2(NUM_BLK + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic put,
    input  logic take,
    output logic full,
    output logic empty
);
    logic [CW-1:0] cnt;

    // Count committed blocks; a put and a take in the same cycle cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (put && !take)
            cnt <= cnt + 1'b1;
        else if (take && !put)
            cnt <= cnt - 1'b1;
    end

    // Flags follow the count directly.
    assign full  = (cnt == CW'(NUM_BLK));
    assign empty = (cnt == '0);
endmodule

// File: rtl/blkq_store.sv
// Slot storage with two independent ports, each with a registered read.
// Assumes the two ports never write the same word in one cycle (the top
// guarantees this because the two sides own different slots while both may write).
module blkq_store #(
    parameter int NUM_BLK   = 4,
    parameter int BLK_WORDS = 8,
    parameter int DATA_W    = 16,
    localparam int DEPTH = NUM_BLK * BLK_WORDS,
    localparam int IW    = $clog2(DEPTH),
    localparam int PW    = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
    localparam int AW    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [PW-1:0]     a_blk,
    input  logic [AW-1:0]     a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [PW-1:0]     b_blk,
    input  logic [AW-1:0]     b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [IW-1:0]     a_idx;
    logic [IW-1:0]     b_idx;

    // Flatten slot and word address into one storage index.
    assign a_idx = IW'(a_blk) * IW'(BLK_WORDS) + IW'(a_addr);
    assign b_idx = IW'(b_blk) * IW'(BLK_WORDS) + IW'(b_addr);

    // Write both ports into the shared array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else begin
            if (a_we)
                mem[a_idx] <= a_wdata;
            if (b_we)
                mem[b_idx] <= b_wdata;
        end
    end

    // Registered read for port A.
    always_ff @(posedge clk) begin
        if (!rst_n)
            a_rdata <= '0;
        else if (a_re)
            a_rdata <= mem[a_idx];
    end

    // Registered read for port B.
    always_ff @(posedge clk) begin
        if (!rst_n)
            b_rdata <= '0;
        else if (b_re)
            b_rdata <= mem[b_idx];
    end
endmodule

// File: rtl/blkq_top.sv
// Block queue channel: NUM_BLK slots of BLK_WORDS words. The producer owns
// the slot at its tail index and the consumer owns the slot at its head index.
// Commands are decoded per side and gated by the full/empty flags.
// Assumes both sides share one clock.
module blkq_top #(
    parameter int NUM_BLK   = 4,
    parameter int BLK_WORDS = 8,
    parameter int DATA_W    = 16,
    localparam int AW = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1,
    localparam int PW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        prd_op,
    input  logic [AW-1:0]     prd_addr,
    input  logic [DATA_W-1:0] prd_wdata,
    output logic [DATA_W-1:0] prd_rdata,
    output logic              prd_full,
    input  logic [1:0]        cns_op,
    input  logic [AW-1:0]     cns_addr,
    input  logic [DATA_W-1:0] cns_wdata,
    output logic [DATA_W-1:0] cns_rdata,
    output logic              cns_empty
);
    import blkq_pkg::*;

    blkq_op_e      p_op;
    blkq_op_e      c_op;
    logic          p_wr;
    logic          p_rd;
    logic          p_cm;
    logic          c_wr;
    logic          c_rd;
    logic          c_cm;
    logic [PW-1:0] tail;
    logic [PW-1:0] head;

    assign p_op = blkq_op_e'(prd_op);
    assign c_op = blkq_op_e'(cns_op);

    // Producer decode: writes and commits are blocked while full.
    always_comb begin
        p_rd = (p_op == OP_READ);
        p_wr = (p_op == OP_WRITE)  && !prd_full;
        p_cm = (p_op == OP_COMMIT) && !prd_full;
    end

    // Consumer decode: every access is blocked while empty.
    always_comb begin
        c_rd = (c_op == OP_READ)   && !cns_empty;
        c_wr = (c_op == OP_WRITE)  && !cns_empty;
        c_cm = (c_op == OP_COMMIT) && !cns_empty;
    end

    blkq_ptr #(.NUM_BLK(NUM_BLK)) u_tail (
        .clk(clk), .rst_n(rst_n), .adv(p_cm), .ptr(tail)
    );

    blkq_ptr #(.NUM_BLK(NUM_BLK)) u_head (
        .clk(clk), .rst_n(rst_n), .adv(c_cm), .ptr(head)
    );

    blkq_occ #(.NUM_BLK(NUM_BLK)) u_occ (
        .clk(clk), .rst_n(rst_n), .put(p_cm), .take(c_cm),
        .full(prd_full), .empty(cns_empty)
    );

    blkq_store #(
        .NUM_BLK(NUM_BLK), .BLK_WORDS(BLK_WORDS), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_we(p_wr), .a_re(p_rd), .a_blk(tail), .a_addr(prd_addr),
        .a_wdata(prd_wdata), .a_rdata(prd_rdata),
        .b_we(c_wr), .b_re(c_rd), .b_blk(head), .b_addr(cns_addr),
        .b_wdata(cns_wdata), .b_rdata(cns_rdata)
    );
endmodule

// File: rtl/blkq_chk.sv
// Port-level checker for blkq_top, attached through bind.
module blkq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        prd_op,
    input logic [1:0]        cns_op,
    input logic              prd_full,
    input logic              cns_empty,
    input logic [DATA_W-1:0] prd_rdata,
    input logic [DATA_W-1:0] cns_rdata
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(prd_full && cns_empty)); // R6

    AST_PRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_op != 2'd1) |=> $stable(prd_rdata)); // R2

    AST_CNS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cns_op != 2'd1) |=> $stable(cns_rdata)); // R2

    AST_COMMIT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_op == 2'd3 && !prd_full && cns_op != 2'd3) |=> !cns_empty); // R3

    AST_FULL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_full && cns_op != 2'd3) |=> prd_full); // R6

    AST_FULL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prd_full) |-> $past(prd_op) == 2'd3); // R6

    AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cns_empty && cns_op == 2'd1) |=> $stable(cns_rdata)); // R7

    AST_EMPTY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cns_empty && prd_op != 2'd3) |=> cns_empty); // R7

    AST_DUAL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_op == 2'd3 && cns_op == 2'd3 && !prd_full && !cns_empty)
        |=> ($stable(prd_full) && $stable(cns_empty))); // R9
endmodule

bind blkq_top blkq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .prd_op(prd_op), .cns_op(cns_op),
    .prd_full(prd_full), .cns_empty(cns_empty),
    .prd_rdata(prd_rdata), .cns_rdata(cns_rdata)
);

// File: tb/sim_blkq_top.sv
// Directed bench for blkq_top: one task per scenario, each checking itself.
module sim_blkq_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int KW = 8;
    localparam int DW = 16;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    prd_op = 2'd0;
    logic [AW-1:0] prd_addr = '0;
    logic [DW-1:0] prd_wdata = '0;
    logic [DW-1:0] prd_rdata;
    logic          prd_full;
    logic [1:0]    cns_op = 2'd0;
    logic [AW-1:0] cns_addr = '0;
    logic [DW-1:0] cns_wdata = '0;
    logic [DW-1:0] cns_rdata;
    logic          cns_empty;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blkq_top #(.NUM_BLK(NB), .BLK_WORDS(KW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .prd_op(prd_op), .prd_addr(prd_addr), .prd_wdata(prd_wdata),
        .prd_rdata(prd_rdata), .prd_full(prd_full),
        .cns_op(cns_op), .cns_addr(cns_addr), .cns_wdata(cns_wdata),
        .cns_rdata(cns_rdata), .cns_empty(cns_empty)
    );

    function automatic logic [DW-1:0] pat(int b, int a);
        return DW'(16'hA000 + b * 256 + a);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle with both sides driven; returns at the next falling edge.
    task automatic cyc(logic [1:0] pop, int pa, logic [DW-1:0] pd,
                       logic [1:0] cop, int ca, logic [DW-1:0] cd);
        prd_op = pop; prd_addr = AW'(pa); prd_wdata = pd;
        cns_op = cop; cns_addr = AW'(ca); cns_wdata = cd;
        @(negedge clk);
        prd_op = 2'd0; cns_op = 2'd0;
    endtask

    task automatic p_op(logic [1:0] op, int a, logic [DW-1:0] d);
        cyc(op, a, d, 2'd0, 0, '0);
    endtask

    task automatic c_op(logic [1:0] op, int a, logic [DW-1:0] d);
        cyc(2'd0, 0, '0, op, a, d);
    endtask

    // Producer fills a whole block in descending address order, then commits.
    task automatic put_block(int b);
        for (int a = KW - 1; a >= 0; a--) p_op(2'd2, a, pat(b, a));
        p_op(2'd3, 0, '0);
    endtask

    // Consumer reads a whole block in a scrambled order, then commits.
    task automatic get_block(int b, string req);
        for (int i = 0; i < KW; i++) begin
            int a = (i * 5 + 3) % KW;
            c_op(2'd1, a, '0);
            chk(req, cns_rdata, pat(b, a));
        end
        c_op(2'd3, 0, '0);
    endtask

    task automatic t_reset();
        chk("R1 empty", cns_empty, 1);
        chk("R1 full", prd_full, 0);
        chk("R1 prd_rdata", prd_rdata, 0);
        chk("R1 cns_rdata", cns_rdata, 0);
    endtask

    task automatic t_prd_scratch();
        p_op(2'd2, 3, 16'h1357);
        p_op(2'd1, 3, '0);
        chk("R2 producer readback", prd_rdata, 16'h1357);
        p_op(2'd0, 4, '0);
        chk("R2 idle holds", prd_rdata, 16'h1357);
        p_op(2'd2, 4, 16'h2468);
        chk("R2 write holds", prd_rdata, 16'h1357);
    endtask

    task automatic t_one_block();
        put_block(1);
        chk("R3 visible after commit", cns_empty, 0);
        get_block(1, "R4 scrambled read");
        chk("R3 freed after release", cns_empty, 1);
    endtask

    task automatic t_order_wrap();
        for (int r = 0; r < 3; r++) begin
            for (int j = 0; j < 3; j++) put_block(10 + r * 3 + j);
            for (int j = 0; j < 3; j++) get_block(10 + r * 3 + j, "R5 R8 order and wrap");
        end
        chk("R8 empty after rounds", cns_empty, 1);
    endtask

    task automatic t_full();
        for (int j = 0; j < NB; j++) put_block(20 + j);
        chk("R6 full raised", prd_full, 1);
        p_op(2'd2, 0, 16'hDEAD);
        p_op(2'd3, 0, '0);
        chk("R6 still full", prd_full, 1);
        c_op(2'd1, 0, '0);
        chk("R6 write ignored", cns_rdata, pat(20, 0));
        c_op(2'd3, 0, '0);
        chk("R6 full cleared", prd_full, 0);
        for (int j = 1; j < NB; j++) begin
            c_op(2'd1, 0, '0);
            chk("R6 head order", cns_rdata, pat(20 + j, 0));
            c_op(2'd3, 0, '0);
        end
        chk("R6 commit ignored", cns_empty, 1);
    endtask

    task automatic t_empty();
        logic [DW-1:0] held;
        held = cns_rdata;
        p_op(2'd2, 2, 16'h1234);
        c_op(2'd1, 5, '0);
        chk("R7 read ignored", cns_rdata, held);
        c_op(2'd2, 2, 16'h5555);
        c_op(2'd3, 0, '0);
        chk("R7 still empty", cns_empty, 1);
        p_op(2'd3, 0, '0);
        chk("R7 visible", cns_empty, 0);
        c_op(2'd1, 2, '0);
        chk("R7 write ignored", cns_rdata, 16'h1234);
        c_op(2'd3, 0, '0);
        chk("R7 no underflow", cns_empty, 1);
    endtask

    task automatic t_dual();
        put_block(30);
        c_op(2'd2, 5, 16'h7777);
        c_op(2'd1, 5, '0);
        chk("R10 consumer scratch", cns_rdata, 16'h7777);
        for (int a = 0; a < KW; a++) p_op(2'd2, a, pat(31, a));
        cyc(2'd3, 0, '0, 2'd3, 0, '0);
        chk("R9 not empty", cns_empty, 0);
        chk("R9 not full", prd_full, 0);
        get_block(31, "R9 next head");
        chk("R9 one block only", cns_empty, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prd_scratch();
        t_one_block();
        t_order_wrap();
        t_full();
        t_empty();
        t_dual();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule